// File: doc/BRIEF.md
# Sine Sample Output Sequencer

This block paces the back end of a direct digital synthesis sine source. The sine table uses a synchronous read, so a word comes out only some clock cycles after its address goes in. The address generator also produces a two-bit quadrant code, and that code must reach the sign logic together with the word read from the same address. The sequencer runs a fixed four-state loop that handles this alignment. In the first state it pulses an address-advance enable for the address generator. It then waits while the memory reads. Next it latches the table word. Last, it loads the signed sample into the output register.

The table stores only magnitudes, from 0 to 127. In the first two quadrants the word is passed through as it is. In the last two quadrants it is negated in two's complement. This gives one full sine period from a quarter-wave table. A new sample appears every four system clocks, with a single-cycle valid strobe. Between strobes the output register holds its value, so the output never shows an intermediate value.

Top module: `dds_out_seq`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `sample` is 0, `sample_vld` is low and `addr_step` is low.
- R2: `addr_step` is high in the cycle that follows the first rising clock edge after reset release. After that it is high for exactly one cycle in every four.
- R3: `sample_vld` is high for exactly one cycle in every four. It is high only in a cycle where `addr_step` is also high. The sample it flags belongs to the address issued by the `addr_step` pulse one period earlier.
- R4: `quadrant` is sampled once per period, on the clock edge that ends the cycle after the `addr_step` cycle. Its value in any other cycle has no effect on the output.
- R5: `tbl_data` is sampled once per period, on the clock edge that ends the second cycle after the `addr_step` cycle. This is two cycles after the new address is presented. Its value in any other cycle has no effect on the output.
- R6: For quadrant codes 0 and 1 (bit 1 clear), the output sample equals the table word unchanged.
- R7: For quadrant codes 2 and 3 (bit 1 set), the output sample is the 8-bit two's complement negation of the table word. A word of 127 gives 8'h81, and a word of 0 gives 0.
- R8: `sample` changes only on the edge that raises `sample_vld`. It holds its value in all other cycles.
- R9: A reset asserted in any state abandons the current sequence. After release, the loop restarts as described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quadrant | input | 2 | Quadrant code of the current table address, from the address generator |
| tbl_data | input | 8 | Read data from the synchronous sine magnitude table |
| addr_step | output | 1 | One-cycle enable that advances the address generator |
| sample_vld | output | 1 | One-cycle strobe marking a new output sample |
| sample | output | 8 | Signed two's complement sine sample |

## Verification
The sign assertions assume that every table word latched in the capture cycle lies in 0..127, so that a non-zero negated value always has its sign bit set. The bench's table model produces only such magnitudes. The bench also assumes that the address generator changes its quadrant only on an `addr_step` edge. Its generator model advances a phase accumulator only on those edges. In the noise scenario, the bench inverts `quadrant` and `tbl_data` outside their sampling cycles. This stays within the assumptions, because the corrupted values are never latched.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;

  // Sequencer phases; the encoding order is the loop order.
  typedef enum logic [1:0] {
    PH_ISSUE = 2'd0,
    PH_WAIT  = 2'd1,
    PH_CAPT  = 2'd2,
    PH_LOAD  = 2'd3
  } seq_phase_t;

  // Loop successor.
  function automatic seq_phase_t next_phase(input seq_phase_t p);
    case (p)
      PH_ISSUE: return PH_WAIT;
      PH_WAIT:  return PH_CAPT;
      PH_CAPT:  return PH_LOAD;
      default:  return PH_ISSUE;
    endcase
  endfunction

endpackage

// File: rtl/dds_seq_fsm.sv
module dds_seq_fsm
  import dds_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic issue_en,
  output logic quad_cap_en,
  output logic data_cap_en,
  output logic load_en
);

  seq_phase_t phase_q;
  logic       primed_q;

  // Reset parks in the load phase with loading suppressed, so the first
  // edge after release enters the issue phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_LOAD;
      primed_q <= 1'b0;
    end else begin
      phase_q <= next_phase(phase_q);
      if (phase_q == PH_ISSUE) primed_q <= 1'b1;
    end
  end

  assign issue_en    = (phase_q == PH_ISSUE);
  assign quad_cap_en = (phase_q == PH_WAIT);
  assign data_cap_en = (phase_q == PH_CAPT);
  assign load_en     = (phase_q == PH_LOAD) && primed_q;

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |=> !issue_en);

endmodule

// File: rtl/dds_seq_capture.sv
module dds_seq_capture #(
  parameter int DATA_W = 8,
  parameter int QUAD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quad_cap_en,
  input  logic              data_cap_en,
  input  logic [QUAD_W-1:0] quad_in,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_q,
  output logic              neg_half_q
);

  logic [QUAD_W-1:0] quad_early_q;

  // Quadrant taken while the address sits at the table input; carried
  // one more cycle so it lands beside the word read from that address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_early_q <= '0;
      word_q       <= '0;
      neg_half_q   <= 1'b0;
    end else begin
      if (quad_cap_en) quad_early_q <= quad_in;
      if (data_cap_en) begin
        word_q     <= word_in;
        neg_half_q <= quad_early_q[QUAD_W-1];
      end
    end
  end

endmodule

// File: rtl/dds_seq_sign.sv
module dds_seq_sign #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              neg_half,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] sample_q,
  output logic              vld_q
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] cond_negate(
    input logic [DATA_W-1:0] m, input logic neg);
    return neg ? (~m + ONE) : m;
  endfunction

  logic [DATA_W-1:0] signed_word;
  assign signed_word = cond_negate(word, neg_half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= load_en;
      if (load_en) sample_q <= signed_word;
    end
  end

  // R6
  pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !neg_half && !word[DATA_W-1]) |=> !sample_q[DATA_W-1]);

  // R7
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && neg_half && !word[DATA_W-1] && word != '0)
      |=> sample_q[DATA_W-1]);

endmodule

// File: rtl/dds_out_seq.sv
module dds_out_seq #(
  parameter int DATA_W = 8,
  parameter int QUAD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QUAD_W-1:0] quadrant,
  input  logic [DATA_W-1:0] tbl_data,
  output logic              addr_step,
  output logic              sample_vld,
  output logic [DATA_W-1:0] sample
);

  logic              issue_en;
  logic              quad_cap_en;
  logic              data_cap_en;
  logic              load_en;
  logic [DATA_W-1:0] word_q;
  logic              neg_half_q;

  dds_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_en    (issue_en),
    .quad_cap_en (quad_cap_en),
    .data_cap_en (data_cap_en),
    .load_en     (load_en)
  );

  dds_seq_capture #(.DATA_W(DATA_W), .QUAD_W(QUAD_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .quad_cap_en (quad_cap_en),
    .data_cap_en (data_cap_en),
    .quad_in     (quadrant),
    .word_in     (tbl_data),
    .word_q      (word_q),
    .neg_half_q  (neg_half_q)
  );

  dds_seq_sign #(.DATA_W(DATA_W)) u_sign (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .neg_half (neg_half_q),
    .word     (word_q),
    .sample_q (sample),
    .vld_q    (sample_vld)
  );

  assign addr_step = issue_en;

  // R3
  valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> addr_step);

  // R8
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |-> $stable(sample));

endmodule

// File: tb/dds_out_seq_test.sv
module dds_out_seq_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] quadrant;
  logic [7:0] tbl_data;
  logic       addr_step, sample_vld;
  logic [7:0] sample;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // Bench-side address generator and table model.
  logic [9:0] acc;
  logic [9:0] acc_seed = 10'd0;
  logic [9:0] step = 10'd1;
  logic [7:0] rom_q;
  logic [1:0] ph;
  logic       noise = 1'b0;
  logic [7:0] exp_q [64];
  logic [5:0] wr;
  int         rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_out_seq uut (
    .clk(clk), .rst_n(rst_n), .quadrant(quadrant), .tbl_data(tbl_data),
    .addr_step(addr_step), .sample_vld(sample_vld), .sample(sample)
  );

  function automatic logic [7:0] mag(input logic [7:0] a);
    if (a == 8'd255) return 8'd127;
    if (a == 8'd0)   return 8'd0;
    return 8'((int'(a) * 37 + 11) % 128);
  endfunction

  function automatic logic [7:0] expect_of(input logic [9:0] p);
    int m = int'(mag(p[7:0]));
    return p[9] ? 8'((256 - m) % 256) : 8'(m);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      acc <= acc_seed; wr <= '0; ph <= 2'd3; rom_q <= '0;
    end else begin
      rom_q <= mag(acc[7:0]);
      if (addr_step) begin
        acc <= acc + step;
        exp_q[wr] <= expect_of(acc + step);
        wr <= wr + 6'd1;
        ph <= 2'd1;
      end else begin
        ph <= ph + 2'd1;
      end
    end
  end

  // Noise corrupts inputs only in cycles where they must be ignored.
  assign quadrant = (noise && ph != 2'd1) ? ~acc[9:8] : acc[9:8];
  assign tbl_data = (noise && ph != 2'd2) ? ~rom_q : rom_q;

  task automatic check(input bit ok, input string req,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic [9:0] seed);
    @(negedge clk);
    rst_n = 1'b0;
    acc_seed = seed;
    repeat (3) begin
      @(negedge clk);
      check(sample == 8'd0 && !sample_vld && !addr_step, "R1",
            {sample_vld, addr_step, sample}, 0);
    end
    rst_n = 1'b1;
    rd = 0;
    @(negedge clk);
    check(addr_step == 1'b1, "R2/R9 first strobe", addr_step, 1);
    @(negedge clk);
    check(addr_step == 1'b0, "R2 single cycle", addr_step, 0);
  endtask

  task automatic run_stream(input string tag, input int n);
    int got = 0;
    int gap = 0;
    int strobe_gap = 0;
    logic [7:0] last = sample;
    for (int cyc = 0; cyc < 40 * n && got < n; cyc++) begin
      @(negedge clk);
      gap++;
      strobe_gap++;
      if (addr_step) begin
        if (got > 0) check(strobe_gap == 4, "R2 period", strobe_gap, 4);
        strobe_gap = 0;
      end
      if (sample_vld) begin
        check(addr_step, "R3 align", addr_step, 1);
        if (got > 0) check(gap == 4, "R3 period", gap, 4);
        check(sample == exp_q[rd[5:0]], tag, sample, exp_q[rd[5:0]]);
        rd++; got++; gap = 0;
        last = sample;
      end else begin
        check(sample == last, "R8 hold", sample, last);
      end
    end
    check(got == n, "R3 sample count", got, n);
  endtask

  task automatic t_positive;
    step = 10'd1; noise = 1'b0;
    do_reset(10'd0);
    run_stream("R6 positive quadrant", 20);
  endtask

  task automatic t_sweep;
    step = 10'h02B; noise = 1'b0;
    do_reset(10'd5);
    run_stream("R6/R7 mixed quadrants", 60);
  endtask

  task automatic t_noise;
    step = 10'h061; noise = 1'b1;
    do_reset(10'd17);
    run_stream("R4/R5 off-cycle inputs ignored", 60);
    noise = 1'b0;
  endtask

  task automatic t_full_scale;
    step = 10'h100; noise = 1'b0;
    do_reset(10'h0FF);
    // 127 in q1, 8'h81 in q2 and q3, 127 in q0
    run_stream("R7 full-scale negation", 8);
  endtask

  task automatic t_zero;
    step = 10'h100; noise = 1'b0;
    do_reset(10'h000);
    run_stream("R7 zero stays zero", 8);
  endtask

  task automatic t_midrun_reset;
    step = 10'h037; noise = 1'b0;
    do_reset(10'd3);
    run_stream("R9 before reset", 5);
    repeat (2) @(negedge clk);
    do_reset(10'd200);
    run_stream("R9 after reset", 10);
  endtask

  initial begin
    t_positive();
    t_sweep();
    t_noise();
    t_full_scale();
    t_zero();
    t_midrun_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule